// File: doc/BRIEF.md
# Split-Array Complementary Write Controller

This controller sequences a memory array that is split into two halves. Each half carries one extra dummy row. The bitline drivers and sense amplifiers sit between the halves and serve both of them. The controller hides the data dependence of write power.

On every write, the addressed row in one half takes the data. In the same pulse, the dummy row of the opposite half takes the bitwise complement, routed through inverting two-way switches. As a result, every column charges the same amount of line whatever the data pattern. On a protected read, the controller raises the addressed row and the opposite dummy row together, and only the addressed half is connected to the sense amplifiers.

Each operation takes one setup cycle and one active cycle, and all lines rest in the hold state in every other cycle. A per-request option disables the dummy write, which saves energy at the cost of protection. A second option turns the dummy-row activation on reads on or off.

Top module: `split_cw_ctrl`

## Requirements
- R1: While reset is low, `req_ready` is 1, `rd_valid` is 0, `sw_inv` and `bl_en` are 0, and every wordline code is 00.
- R2: A write accepted at the clock edge where `req_valid` and `req_ready` are both high (edge k) drives code 01 (write level) on one row during the cycle after edge k+1. The row is index `req_addr[ADDR_W-2:0]` in the half given by `req_addr[ADDR_W-1]` (0 selects `wl_h0`/`bl_h0`, 1 selects `wl_h1`/`bl_h1`). That half's bitlines carry the data, and the row holds the data after edge k+2.
- R3: With `cfg_dummy_off` at 0, the same write drives code 10 (grounded, active) on index `2**(ADDR_W-1)` (the dummy row) of the opposite half, with `bl_en` = 11. The opposite bitlines carry the bitwise complement, so the dummy row holds the complement afterwards.
- R4: With `cfg_dummy_off` at 1 when the write is accepted, the dummy wordline stays at 00, only the addressed half's `bl_en` bit is set, and neither dummy row changes.
- R5: Each operation activates at most one normal row across both halves. No address reaches a dummy row, and no row other than the ones named in R2/R3 changes.
- R6: `sw_inv[h]` (1 = half h receives the inverted data path) is loaded at acceptance and holds through the setup and active cycles. It is 1 only for the half opposite a write with the dummy write enabled.
- R7: With `cfg_prot_rd` at 1, a read drives code 11 on the addressed row and on the opposite dummy row. Only `sa_conn[half]` is set, and `rd_data` returns the addressed row's contents with `rd_valid` high in the cycle after edge k+2.
- R8: With `cfg_prot_rd` at 0, a read drives code 11 on the addressed row only, and the dummy rows stay at 00.
- R9: Outside the active cycle, all wordline codes are 00, and `bl_en`, `bl_h0`, `bl_h1` and `sa_conn` are 0.
- R10: `req_ready` is 0 from acceptance until the operation ends. A request presented meanwhile is ignored and changes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dummy_off | input | 1 | 1 = skip the complementary dummy write |
| cfg_prot_rd | input | 1 | 1 = reads also activate the opposite dummy row |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Row address; MSB picks the half |
| req_wdata | input | DATA_W | Write data |
| wl_h0 | output | 2*(2**(ADDR_W-1)+1) | Wordline codes of half 0, top index is the dummy row |
| wl_h1 | output | 2*(2**(ADDR_W-1)+1) | Wordline codes of half 1, top index is the dummy row |
| sw_inv | output | 2 | Per-half inverting switch select |
| bl_en | output | 2 | Per-half bitline drive enable |
| bl_h0 | output | DATA_W | Bitline values toward half 0 |
| bl_h1 | output | DATA_W | Bitline values toward half 1 |
| sa_conn | output | 2 | Per-half connection to the sense amplifiers |
| sa_data | input | DATA_W | Sensed data from the shared amplifiers |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read result |

## Verification
A stale or wrong captured request shows up in the active cycle itself, two edges after acceptance. It appears as a wordline code on the wrong row or half, or as bitlines that are not exact complements across the halves. A steering register that loses its value would let `sw_inv` change between setup and active. A sequencer that leaves the active state late or early would break the hold condition in the very next cycle. Corruption of the array contents appears in the full row comparison one cycle after each pulse, or in the next read of the affected row.

// File: rtl/split_cw_pkg.sv
// Shared codes for the split-array complementary write controller.
// Assumes a 2-bit wordline drive code per row and a three-state sequencer.
package split_cw_pkg;
    typedef enum logic [1:0] {
        WL_IDLE = 2'b00,   // hold, wordline released
        WL_VW   = 2'b01,   // driven to write level
        WL_GND  = 2'b10,   // active, driven to ground (complement write)
        WL_RD   = 2'b11    // read bias
    } wl_lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SETUP = 2'b01,
        ST_ACT   = 2'b10
    } seq_st_e;
endpackage

// File: rtl/split_cw_seq.sv
// Request sequencer: accepts one request when idle, holds it through a setup
// cycle (switch steering settles) and an active cycle (pulse / sense), and
// captures read data at the end of the active cycle.
// Assumes sa_data is valid during the active cycle of a read.
module split_cw_seq
    import split_cw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_dummy_off,
    input  logic              cfg_prot_rd,
    input  logic [DATA_W-1:0] sa_data,
    output seq_st_e           st,
    output logic              act,
    output logic              req_ready,
    output logic              op_write,
    output logic              op_half,
    output logic [ADDR_W-2:0] op_row,
    output logic [DATA_W-1:0] op_data,
    output logic              op_doff,
    output logic              op_prot,
    output logic [1:0]        sw_inv,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ROW_W = ADDR_W - 1;

    seq_st_e st_q;
    logic    accept;

    assign accept    = (st_q == ST_IDLE) && req_valid;
    assign st        = st_q;
    assign act       = (st_q == ST_ACT);
    assign req_ready = (st_q == ST_IDLE);

    // Advance idle -> setup -> active -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:  if (req_valid) st_q <= ST_SETUP;
                ST_SETUP: st_q <= ST_ACT;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request and its options at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_half  <= 1'b0;
            op_row   <= '0;
            op_data  <= '0;
            op_doff  <= 1'b0;
            op_prot  <= 1'b0;
        end else if (accept) begin
            op_write <= req_write;
            op_half  <= req_addr[ADDR_W-1];
            op_row   <= req_addr[ROW_W-1:0];
            op_data  <= req_wdata;
            op_doff  <= cfg_dummy_off;
            op_prot  <= cfg_prot_rd;
        end
    end

    // Register switch steering so it is settled before the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_inv <= 2'b00;
        end else if (accept) begin
            for (int h = 0; h < 2; h++) begin
                sw_inv[h] <= req_write && !cfg_dummy_off
                             && (req_addr[ADDR_W-1] != 1'(h));
            end
        end
    end

    // Capture sensed data at the end of a read's active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= act && !op_write;
            if (act && !op_write) rd_data <= sa_data;
        end
    end
endmodule

// File: rtl/split_cw_wl.sv
// Wordline decoder for one half: rows 0..ROWS-1 are addressable, index ROWS
// is the dummy row, reached only for operations aimed at the other half.
// Assumes op_* are stable while act is high.
module split_cw_wl
    import split_cw_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter bit HALF_ID = 1'b0
) (
    input  logic                     act,
    input  logic                     op_write,
    input  logic                     op_half,
    input  logic [$clog2(ROWS)-1:0]  op_row,
    input  logic                     op_doff,
    input  logic                     op_prot,
    output logic [ROWS:0][1:0]       wl
);
    localparam int RW = $clog2(ROWS);

    logic mine;
    logic other;

    assign mine  = act && (op_half == HALF_ID);
    assign other = act && (op_half != HALF_ID);

    // Drive the addressed normal row of this half.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign wl[r] = (mine && (op_row == RW'(r)))
                       ? (op_write ? WL_VW : WL_RD) : WL_IDLE;
    end

    // Drive the dummy row for complement writes or masked reads.
    assign wl[ROWS] = !other  ? WL_IDLE :
                      op_write ? (op_doff ? WL_IDLE : WL_GND) :
                                 (op_prot ? WL_RD : WL_IDLE);
endmodule

// File: rtl/split_cw_bl.sv
// Bitline steering for one half: true or inverted data through the two-way
// switch, drive enable, and connection to the shared sense amplifiers.
// Assumes sw_inv is registered upstream and stable during act.
module split_cw_bl #(
    parameter int DATA_W  = 8,
    parameter bit HALF_ID = 1'b0
) (
    input  logic              act,
    input  logic              op_write,
    input  logic              op_half,
    input  logic              sw_inv,
    input  logic [DATA_W-1:0] op_data,
    output logic              bl_en,
    output logic [DATA_W-1:0] bl,
    output logic              sa_conn
);
    // Enable this half's drivers for its own write or a complement write.
    assign bl_en   = act && op_write && ((op_half == HALF_ID) || sw_inv);
    // Select true or inverted data, released to zero in hold.
    assign bl      = !bl_en ? '0 : (sw_inv ? ~op_data : op_data);
    // Connect only the addressed half to the amplifiers on reads.
    assign sa_conn = act && !op_write && (op_half == HALF_ID);
endmodule

// File: rtl/split_cw_ctrl.sv
// Top of the split-array complementary write controller: one sequencer, and
// one wordline decoder plus one bitline steering slice per half.
// Assumes the array model/analog side acts only on the active-cycle lines.
module split_cw_ctrl
    import split_cw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_dummy_off,
    input  logic                          cfg_prot_rd,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic [2**(ADDR_W-1):0][1:0]   wl_h0,
    output logic [2**(ADDR_W-1):0][1:0]   wl_h1,
    output logic [1:0]                    sw_inv,
    output logic [1:0]                    bl_en,
    output logic [DATA_W-1:0]             bl_h0,
    output logic [DATA_W-1:0]             bl_h1,
    output logic [1:0]                    sa_conn,
    input  logic [DATA_W-1:0]             sa_data,
    output logic                          rd_valid,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int ROWS = 2**(ADDR_W-1);

    seq_st_e                      seq_st;
    logic                         act;
    logic                         op_write;
    logic                         op_half;
    logic [ADDR_W-2:0]            op_row;
    logic [DATA_W-1:0]            op_data;
    logic                         op_doff;
    logic                         op_prot;
    logic [1:0][ROWS:0][1:0]      wl_all;
    logic [1:0][DATA_W-1:0]       bl_all;

    split_cw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_dummy_off(cfg_dummy_off), .cfg_prot_rd(cfg_prot_rd),
        .sa_data(sa_data),
        .st(seq_st), .act(act), .req_ready(req_ready),
        .op_write(op_write), .op_half(op_half), .op_row(op_row),
        .op_data(op_data), .op_doff(op_doff), .op_prot(op_prot),
        .sw_inv(sw_inv), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        split_cw_wl #(.ROWS(ROWS), .HALF_ID(1'(h))) u_wl (
            .act(act), .op_write(op_write), .op_half(op_half),
            .op_row(op_row), .op_doff(op_doff), .op_prot(op_prot),
            .wl(wl_all[h])
        );
        split_cw_bl #(.DATA_W(DATA_W), .HALF_ID(1'(h))) u_bl (
            .act(act), .op_write(op_write), .op_half(op_half),
            .sw_inv(sw_inv[h]), .op_data(op_data),
            .bl_en(bl_en[h]), .bl(bl_all[h]), .sa_conn(sa_conn[h])
        );
    end

    assign wl_h0 = wl_all[0];
    assign wl_h1 = wl_all[1];
    assign bl_h0 = bl_all[0];
    assign bl_h1 = bl_all[1];
endmodule

// File: rtl/split_cw_chk.sv
// Property checker for split_cw_ctrl, attached by bind below.
// Assumes visibility of the top's sequencer state and captured options.
module split_cw_chk
    import split_cw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_ready,
    input seq_st_e                     seq_st,
    input logic                        op_write,
    input logic                        op_doff,
    input logic [2**(ADDR_W-1):0][1:0] wl_h0,
    input logic [2**(ADDR_W-1):0][1:0] wl_h1,
    input logic [1:0]                  sw_inv,
    input logic [1:0]                  bl_en,
    input logic [DATA_W-1:0]           bl_h0,
    input logic [DATA_W-1:0]           bl_h1,
    input logic [1:0]                  sa_conn,
    input logic                        rd_valid
);
    localparam int ROWS = 2**(ADDR_W-1);

    logic [2*ROWS-1:0] row_on;

    // Flag every active normal row across both halves.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            row_on[r]        = (wl_h0[r] != WL_IDLE);
            row_on[ROWS + r] = (wl_h1[r] != WL_IDLE);
        end
    end

    assert_one_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_on));

    assert_hold_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st != ST_ACT) |-> (wl_h0 == '0 && wl_h1 == '0 && bl_en == 2'b00
                                && sa_conn == 2'b00));

    assert_sw_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_ACT) |-> $stable(sw_inv));

    assert_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_ACT && op_write && !op_doff)
            |-> (bl_en == 2'b11 && bl_h0 == ~bl_h1));

    assert_dummy_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_ACT && op_write && op_doff) |-> $onehot(bl_en));

    assert_rd_after_sense_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(sa_conn != 2'b00));

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind split_cw_ctrl split_cw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_split_cw_ctrl.sv
module tb_split_cw_ctrl;
    import split_cw_pkg::*;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int ROWS       = 2**(ADDR_W-1);
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dummy_off = 1'b0;
    logic cfg_prot_rd = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready;
    logic [ROWS:0][1:0] wl_h0, wl_h1;
    logic [1:0] sw_inv, bl_en, sa_conn;
    logic [DATA_W-1:0] bl_h0, bl_h1, sa_data, rd_data;
    logic rd_valid;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] arr     [2][ROWS+1];
    logic [DATA_W-1:0] ref_arr [2][ROWS+1];
    logic [DATA_W-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    split_cw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dummy_off(cfg_dummy_off), .cfg_prot_rd(cfg_prot_rd),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .wl_h0(wl_h0), .wl_h1(wl_h1), .sw_inv(sw_inv), .bl_en(bl_en),
        .bl_h0(bl_h0), .bl_h1(bl_h1), .sa_conn(sa_conn), .sa_data(sa_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Array model: a row takes its half's bitlines when driven and selected.
    always @(posedge clk) begin : array_model
        for (int h = 0; h < 2; h++) begin
            for (int r = 0; r <= ROWS; r++) begin
                if (!rst_n) arr[h][r] <= '0;
                else if (bl_en[h] && ((h == 0 ? wl_h0[r] : wl_h1[r]) == WL_VW ||
                                      (h == 0 ? wl_h0[r] : wl_h1[r]) == WL_GND))
                    arr[h][r] <= (h == 0) ? bl_h0 : bl_h1;
            end
        end
    end

    // Sense model: connected half, rows biased for read.
    always_comb begin : sense_model
        sa_data = '0;
        for (int h = 0; h < 2; h++)
            for (int r = 0; r <= ROWS; r++)
                if (sa_conn[h] && (h == 0 ? wl_h0[r] : wl_h1[r]) == WL_RD)
                    sa_data = sa_data | arr[h][r];
    end

    task automatic chk(input bit ok, input string req,
                       input logic [39:0] act, input logic [39:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected read data as results appear (R7, R8).
    always @(negedge clk) begin : monitor
        logic [DATA_W-1:0] e;
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected rd_valid", rd_data, 0);
            else begin
                e = exp_q.pop_front();
                chk(rd_data == e, "R7 read data", rd_data, e);
            end
        end
    end

    task automatic check_idle_lines(input string tag);
        chk(wl_h0 == '0 && wl_h1 == '0, tag, {wl_h1, wl_h0}, 0);
        chk(bl_en == 2'b00 && sa_conn == 2'b00 && bl_h0 == '0 && bl_h1 == '0,
            tag, {bl_en, sa_conn, bl_h1, bl_h0}, 0);
    endtask

    task automatic check_array(input string tag);
        int bad = 0;
        logic [DATA_W-1:0] a = '0, e = '0;
        for (int h = 0; h < 2; h++)
            for (int r = 0; r <= ROWS; r++)
                if (arr[h][r] !== ref_arr[h][r]) begin
                    if (bad == 0) begin a = arr[h][r]; e = ref_arr[h][r]; end
                    bad++;
                end
        chk(bad == 0, tag, a, e);
    endtask

    // Driver: issue one operation, check the lines, push expected results.
    task automatic do_op(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input bit poke);
        int h = int'(a[ADDR_W-1]);
        int r = int'(a[ADDR_W-2:0]);
        int oh = 1 - h;
        bit off = cfg_dummy_off;
        bit prot = cfg_prot_rd;
        logic [1:0][ROWS:0][1:0] ew = '0;
        logic [1:0] exp_sw = (wr && !off) ? (2'b01 << oh) : 2'b00;
        logic [1:0] exp_en = off ? (2'b01 << h) : 2'b11;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);                                 // setup cycle
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 busy during setup", req_ready, 0);
        check_idle_lines("R9 hold in setup");
        chk(sw_inv == exp_sw, "R6 steering at setup", sw_inv, exp_sw);
        if (poke) begin
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = a ^ 4'h1; req_wdata = 8'h5A;
        end
        @(negedge clk);                                 // active cycle
        req_valid = 1'b0;
        ew[h][r] = wr ? WL_VW : WL_RD;
        if (wr) ew[oh][ROWS] = off ? WL_IDLE : WL_GND;
        else    ew[oh][ROWS] = prot ? WL_RD : WL_IDLE;
        chk({wl_h1, wl_h0} == {ew[1], ew[0]},
            wr ? (off ? "R4 wordlines" : "R3 wordlines") : (prot ? "R7 wordlines" : "R8 wordlines"),
            {wl_h1, wl_h0}, {ew[1], ew[0]});
        chk(sw_inv == exp_sw, "R6 steering stable in pulse", sw_inv, exp_sw);
        if (wr) begin
            chk(bl_en == exp_en, off ? "R4 bitline enables" : "R3 bitline enables", bl_en, exp_en);
            chk((h == 0 ? bl_h0 : bl_h1) == d, "R2 data bitlines",
                (h == 0 ? bl_h0 : bl_h1), d);
            if (!off)
                chk((oh == 0 ? bl_h0 : bl_h1) == ~d, "R3 complement bitlines",
                    (oh == 0 ? bl_h0 : bl_h1), ~d);
            ref_arr[h][r] = d;
            if (!off) ref_arr[oh][ROWS] = ~d;
        end else begin
            chk(sa_conn == (2'b01 << h), "R7 amplifier connection", sa_conn, 2'b01 << h);
            exp_q.push_back(ref_arr[h][r]);
        end
        @(negedge clk);                                 // back in hold
        check_idle_lines("R9 hold after pulse");
        check_array(wr ? "R5 array contents after write" : "R5 array unchanged by read");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R1-chain timeout actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        for (int h = 0; h < 2; h++)
            for (int r = 0; r <= ROWS; r++) ref_arr[h][r] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1 && rd_valid == 1'b0, "R1 ready/valid in reset",
            {req_ready, rd_valid}, 2'b10);
        chk(sw_inv == 2'b00 && bl_en == 2'b00, "R1 switches in reset", {sw_inv, bl_en}, 0);
        chk(wl_h0 == '0 && wl_h1 == '0, "R1 wordlines in reset", {wl_h1, wl_h0}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(1'b1, 4'h2, 8'hA5, 1'b0);     // R2, R3 half 0
        do_op(1'b1, 4'hA, 8'h3C, 1'b0);     // R2, R3 half 1
        do_op(1'b0, 4'h2, 8'h00, 1'b0);     // R7 protected read
        do_op(1'b0, 4'hA, 8'h00, 1'b0);
        cfg_prot_rd = 1'b0;
        do_op(1'b0, 4'h2, 8'h00, 1'b0);     // R8 unprotected read
        do_op(1'b1, 4'h0, 8'h00, 1'b0);     // all-zero pattern
        do_op(1'b1, 4'hF, 8'hFF, 1'b0);     // all-one pattern
        do_op(1'b1, 4'h5, 8'h81, 1'b1);     // R10 poke during busy
        do_op(1'b0, 4'h4, 8'h00, 1'b0);     // R10 poked row untouched
        do_op(1'b0, 4'h5, 8'h00, 1'b0);
        cfg_dummy_off = 1'b1;
        do_op(1'b1, 4'h9, 8'h77, 1'b0);     // R4 dummy write skipped
        do_op(1'b0, 4'h9, 8'h00, 1'b0);
        cfg_dummy_off = 1'b0;
        // R5: every address, both halves
        for (int i = 0; i < 2*ROWS; i++)
            do_op(1'b1, ADDR_W'(i), DATA_W'(i*29 + 3), 1'b0);
        for (int i = 0; i < 2*ROWS; i++) begin
            cfg_prot_rd = i[0];
            do_op(1'b0, ADDR_W'(i), 8'h00, 1'b0);
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule